// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block gives a small microcontroller eight interrupt-capable input pins. Each pin passes through a two-stage synchronizer and then an edge detector. A per-pin sense mode chooses what counts as an event: a rising edge, a falling edge, either edge, or a low level. A detected edge sets that pin's flag. The flag is then combined with the pin's enable bit and a global interrupt enable to form a pending request. When several requests are pending, a priority encoder gives the CPU one request line and the vector index of the lowest-numbered pin.

Two byte-wide registers sit on a simple single-cycle register bus. The first is the enable mask. The second is the flag register, in which writing a one clears a bit. The CPU also clears a flag by acknowledging that pin's vector. Pins in level mode keep their flag at zero, and their request follows the pin level directly. Pins are sensed whatever their direction, so software can raise an interrupt by driving an output pin. An input-buffer-disable signal from the sleep controller pulls the internal value of the lower four pins low. The transition this causes is sensed like any other pin change.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, the mask register (bus address 0) and the flag register (bus address 1) both read 0x00. A write to address 0 stores the byte in the mask, and a read of address 0 returns it.
- R2: `irq_req` is high exactly when `gie` is 1 and at least one pin has its mask bit set and is active. A pin is active when its flag is set, or when it is in level mode with its synchronized value low.
- R3: The sense mode of pin i is `sense_mode[2i+1:2i]`: 11 = rising edge, 10 = falling edge, 01 = either edge. The flag sets on the third rising clock edge after the pin takes its new value.
- R4: A transition that the pin's mode does not select leaves its flag unchanged.
- R5: A bus write to address 1 clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R6: While `irq_ack` is high, the flag whose index is on `ack_vec` clears at the next clock edge.
- R7: When several pins are pending, `irq_vec` carries the index of the lowest-numbered one.
- R8: Sense mode 00 selects low-level sensing. In that mode the pin's flag reads 0 from the next cycle on, and the pin's request is active while the synchronized pin is low.
- R9: If a detected edge and a clear (bus write or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R10: While `ibuf_off` is high, pins 0 to 3 are seen internally as low, and the resulting transitions set flags as sensed. Pins 4 to 7 are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Raw pin levels, asynchronous |
| ibuf_off | input | 1 | Input-buffer disable from sleep control; forces pins 0-3 low |
| sense_mode | input | 16 | Two bits per pin: 00 low level, 01 either edge, 10 falling, 11 rising |
| gie | input | 1 | Global interrupt enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 mask, 1 flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register, combinational |
| irq_ack | input | 1 | CPU has taken the vector on ack_vec |
| ack_vec | input | 3 | Index of the acknowledged pin |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 3 | Index of the winning pending pin |

## Verification
The assertions assume a single-cycle bus in which a write strobe and its address and data are valid together at the clock edge. They also assume that `ack_vec` is a valid pin index whenever `irq_ack` is high. The bench drives every input at the falling clock edge. It raises the acknowledge only for an index that is currently on `irq_vec`, and it keeps pins low through reset, so the synchronizers start in agreement with the pins. Sense modes change only while no edge of the affected pin is still in flight, except in the level-mode test, which does this on purpose.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic {
        REG_MASK = 1'b0,
        REG_FLAG = 1'b1
    } regsel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic edge_hits(sense_e mode, edge_t ev);
        logic hit;
        case (mode)
            SENSE_RISE: hit = ev.rise;
            SENSE_FALL: hit = ev.fall;
            SENSE_ANY:  hit = ev.rise | ev.fall;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int NPIN   = 8,
    parameter int NGATED = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pin_in,
    input  logic            ibuf_off,
    output logic [NPIN-1:0] pin_s
);
    logic [NPIN-1:0] gated;
    logic [NPIN-1:0] stage1;
    logic [NPIN-1:0] stage2;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        if (i < NGATED) begin : g_gated
            assign gated[i] = pin_in[i] & ~ibuf_off;
        end else begin : g_plain
            assign gated[i] = pin_in[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gated;
            stage2 <= stage1;
        end
    end

    assign pin_s = stage2;

    // R10: buffer-disabled pins reach the second stage as zero two cycles later
    assert_gate_low_R10: assert property (@(posedge clk) disable iff (rst)
        (ibuf_off && !rst) |=> ##1 ($past(rst, 2) || (stage2[NGATED-1:0] == '0)));

endmodule

// File: rtl/extint_detect.sv
module extint_detect
    import extint_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPIN-1:0]   pin_s,
    input  logic [2*NPIN-1:0] sense_mode,
    output logic [NPIN-1:0]   set_vec,
    output logic [NPIN-1:0]   level_vec,
    output logic [NPIN-1:0]   level_act
);
    logic [NPIN-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= pin_s;
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_det
        sense_e mode;
        edge_t  ev;
        always_comb begin
            mode         = sense_e'(sense_mode[2*i +: 2]);
            ev.rise      = pin_s[i] & ~prev[i];
            ev.fall      = ~pin_s[i] & prev[i];
            set_vec[i]   = edge_hits(mode, ev);
            level_vec[i] = (mode == SENSE_LOW);
            level_act[i] = (mode == SENSE_LOW) & ~pin_s[i];
        end
    end

    // R4: no event is reported for a pin whose value did not move
    assert_no_event_when_stable_R4: assert property (@(posedge clk) disable iff (rst)
        ((set_vec & ~(pin_s ^ prev)) == '0));

endmodule

// File: rtl/extint_regs.sv
module extint_regs
    import extint_pkg::*;
#(
    parameter int NPIN = 8,
    localparam int VW  = $clog2(NPIN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic            bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    output logic [NPIN-1:0] bus_rdata,
    input  logic            irq_ack,
    input  logic [VW-1:0]   ack_vec,
    input  logic [NPIN-1:0] set_vec,
    input  logic [NPIN-1:0] level_vec,
    output logic [NPIN-1:0] mask_q,
    output logic [NPIN-1:0] flag_q
);
    regsel_e         sel;
    logic [NPIN-1:0] ack_oh;
    logic [NPIN-1:0] wr_clr;
    logic [NPIN-1:0] flag_d;

    always_comb begin
        sel    = regsel_e'(bus_addr);
        ack_oh = irq_ack ? (NPIN'(1) << ack_vec) : '0;
        wr_clr = (bus_wr && sel == REG_FLAG) ? bus_wdata : '0;
        flag_d = ((flag_q & ~(wr_clr | ack_oh)) | set_vec) & ~level_vec;
        bus_rdata = (sel == REG_MASK) ? mask_q : flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            flag_q <= '0;
        end else begin
            if (bus_wr && sel == REG_MASK) mask_q <= bus_wdata;
            flag_q <= flag_d;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (mask_q == '0 && flag_q == '0));

    assert_mask_write_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr) |=> (mask_q == $past(bus_wdata)));

    assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr) |=> ((flag_q & $past(bus_wdata) & ~$past(set_vec)) == '0));

    assert_ack_clear_R6: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> ((flag_q & $past(ack_oh) & ~$past(set_vec)) == '0));

    assert_level_zero_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & $past(level_vec)) == '0));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((~flag_q & $past(set_vec)) == '0));

endmodule

// File: rtl/extint_arb.sv
module extint_arb #(
    parameter int NPIN = 8,
    localparam int VW  = $clog2(NPIN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pend,
    output logic            req,
    output logic [VW-1:0]   vec
);
    always_comb begin
        req = |pend;
        vec = '0;
        for (int i = NPIN - 1; i >= 0; i--) begin
            if (pend[i]) vec = VW'(i);
        end
    end

    assert_winner_pending_R7: assert property (@(posedge clk) disable iff (rst)
        req |-> (pend[vec] && ((pend & ((NPIN'(1) << vec) - NPIN'(1))) == '0)));

    assert_req_any_R2: assert property (@(posedge clk) disable iff (rst)
        (pend != '0) |-> req);

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int NGATED = 4,
    localparam int VW    = $clog2(NPIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPIN-1:0]   pin_in,
    input  logic              ibuf_off,
    input  logic [2*NPIN-1:0] sense_mode,
    input  logic              gie,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic              irq_ack,
    input  logic [VW-1:0]     ack_vec,
    output logic              irq_req,
    output logic [VW-1:0]     irq_vec
);
    logic [NPIN-1:0] pin_s;
    logic [NPIN-1:0] set_vec;
    logic [NPIN-1:0] level_vec;
    logic [NPIN-1:0] level_act;
    logic [NPIN-1:0] mask_q;
    logic [NPIN-1:0] flag_q;
    logic [NPIN-1:0] pend;

    extint_sync #(.NPIN(NPIN), .NGATED(NGATED)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in), .ibuf_off(ibuf_off), .pin_s(pin_s)
    );

    extint_detect #(.NPIN(NPIN)) u_detect (
        .clk(clk), .rst(rst), .pin_s(pin_s), .sense_mode(sense_mode),
        .set_vec(set_vec), .level_vec(level_vec), .level_act(level_act)
    );

    extint_regs #(.NPIN(NPIN)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
        .ack_vec(ack_vec), .set_vec(set_vec), .level_vec(level_vec),
        .mask_q(mask_q), .flag_q(flag_q)
    );

    assign pend = (flag_q | level_act) & mask_q & {NPIN{gie}};

    extint_arb #(.NPIN(NPIN)) u_arb (
        .clk(clk), .rst(rst), .pend(pend), .req(irq_req), .vec(irq_vec)
    );

    assert_gie_gate_R2: assert property (@(posedge clk) disable iff (rst)
        !gie |-> !irq_req);

endmodule

// File: tb/extint_ctrl_test.sv
module extint_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pin_in = '0;
    logic        ibuf_off = 1'b0;
    logic [15:0] sense_mode = 16'hFFFF;
    logic        gie = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_ack = 1'b0;
    logic [2:0]  ack_vec = '0;
    logic        irq_req;
    logic [2:0]  irq_vec;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    extint_ctrl uut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .ibuf_off(ibuf_off),
        .sense_mode(sense_mode), .gie(gie), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
        .ack_vec(ack_vec), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit addr, input logic [7:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input bit addr, output logic [7:0] data);
        bus_addr = addr;
        #1 data = bus_rdata;
    endtask

    task automatic check_flags(input logic [7:0] exp, input string req);
        logic [7:0] v;
        rd(1'b1, v);
        check(v == exp, req, v, exp);
    endtask

    function automatic logic [2:0] lowest(input logic [7:0] m);
        logic [2:0] r = '0;
        for (int i = 7; i >= 0; i--) if (m[i]) r = 3'(i);
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        cycles(3);
        rst = 1'b0;
        cycles(1);

        // R1 reset values
        rd(1'b0, v); check(v == 8'h00, "R1 mask reset", v, 0);
        check_flags(8'h00, "R1 flag reset");
        check(irq_req == 1'b0, "R1 req reset", irq_req, 0);

        // R1 mask write and read back
        for (int k = 0; k < 8; k++) begin
            logic [7:0] pat = 8'h5A ^ 8'(k * 37);
            wr(1'b0, pat);
            rd(1'b0, v); check(v == pat, "R1 mask rw", v, pat);
        end
        wr(1'b0, 8'h00);

        // R3/R4 sweep: each pin, each edge mode, both directions
        for (int p = 0; p < 8; p++) begin
            for (int m = 1; m < 4; m++) begin
                sense_mode = 16'hFFFF;
                sense_mode[2*p +: 2] = 2'(m);
                cycles(1);
                wr(1'b1, 8'hFF);
                pin_in[p] = 1'b1;
                cycles(4);
                check_flags((m == 1 || m == 3) ? 8'(1 << p) : 8'h00, "R3 R4 rise");
                wr(1'b1, 8'hFF);
                pin_in[p] = 1'b0;
                cycles(4);
                check_flags((m == 1 || m == 2) ? 8'(1 << p) : 8'h00, "R3 R4 fall");
                wr(1'b1, 8'hFF);
            end
        end
        sense_mode = 16'hFFFF;

        // R3 exact latency: flag set on third rising edge after the change
        wr(1'b1, 8'hFF);
        @(negedge clk); pin_in[6] = 1'b1;
        cycles(2);
        check_flags(8'h00, "R3 not before third edge");
        cycles(1);
        check_flags(8'h40, "R3 at third edge");
        pin_in[6] = 1'b0;
        cycles(4);
        wr(1'b1, 8'hFF);

        // R5 write-one-to-clear
        pin_in = 8'hFF;
        cycles(4);
        check_flags(8'hFF, "R5 setup");
        wr(1'b1, 8'h00);
        check_flags(8'hFF, "R5 zero write no effect");
        wr(1'b1, 8'h55);
        check_flags(8'hAA, "R5 partial clear");
        wr(1'b1, 8'hFF);
        check_flags(8'h00, "R5 full clear");
        pin_in = 8'h00;
        cycles(4);

        // R9 set wins over a clear in the same cycle
        check_flags(8'h00, "R9 setup");
        @(negedge clk); pin_in[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h01;
        @(negedge clk); bus_wr = 1'b0;
        check_flags(8'h01, "R9 set wins");
        wr(1'b1, 8'h01);
        check_flags(8'h00, "R9 later clear");
        pin_in = 8'h00;
        cycles(4);

        // R2/R7 sweep over mask and global enable with all flags set
        pin_in = 8'hFF;
        cycles(4);
        for (int g = 0; g < 2; g++) begin
            gie = g[0];
            for (int mk = 0; mk < 256; mk++) begin
                wr(1'b0, 8'(mk));
                #1;
                check(irq_req == (g == 1 && mk != 0), "R2 request", irq_req, (g == 1 && mk != 0));
                if (g == 1 && mk != 0)
                    check(irq_vec == lowest(8'(mk)), "R7 priority", irq_vec, lowest(8'(mk)));
            end
        end
        wr(1'b1, 8'hFF);
        pin_in = 8'h00;
        cycles(4);

        // R6 acknowledge clears the taken flag
        wr(1'b0, 8'hFF);
        pin_in = 8'h28;
        cycles(4);
        #1 check(irq_req && irq_vec == 3'd3, "R7 first vector", irq_vec, 3);
        @(negedge clk); irq_ack = 1'b1; ack_vec = 3'd3;
        @(negedge clk); irq_ack = 1'b0;
        check_flags(8'h20, "R6 ack clears pin3");
        #1 check(irq_req && irq_vec == 3'd5, "R6 next vector", irq_vec, 5);
        @(negedge clk); irq_ack = 1'b1; ack_vec = 3'd5;
        @(negedge clk); irq_ack = 1'b0;
        check_flags(8'h00, "R6 ack clears pin5");
        #1 check(irq_req == 1'b0, "R6 no request left", irq_req, 0);
        pin_in = 8'h00;
        cycles(4);

        // R8 level sensing
        pin_in[2] = 1'b1;
        cycles(4);
        check_flags(8'h04, "R8 setup edge flag");
        sense_mode[5:4] = 2'b00;
        cycles(2);
        check_flags(8'h00, "R8 flag forced zero");
        #1 check(irq_req == 1'b0, "R8 no request while high", irq_req, 0);
        pin_in[2] = 1'b0;
        cycles(4);
        #1 check(irq_req && irq_vec == 3'd2, "R8 request while low", irq_vec, 2);
        check_flags(8'h00, "R8 flag stays zero");
        wr(1'b1, 8'hFF);
        #1 check(irq_req == 1'b1, "R8 request unaffected by clear", irq_req, 1);
        pin_in[2] = 1'b1;
        cycles(4);
        #1 check(irq_req == 1'b0, "R8 request drops", irq_req, 0);
        sense_mode = 16'hFFFF;
        wr(1'b0, 8'h00);
        gie = 1'b0;

        // R10 buffer disable on lower four pins
        pin_in = 8'hFF;
        cycles(4);
        sense_mode = 16'hAAAA;
        wr(1'b1, 8'hFF);
        check_flags(8'h00, "R10 setup");
        ibuf_off = 1'b1;
        cycles(4);
        check_flags(8'h0F, "R10 gated pins fall");
        ibuf_off = 1'b0;
        cycles(4);
        check_flags(8'h0F, "R10 release rises unsensed");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule